// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Register

This block is the digital front end of a two-channel, parallel-input current-steering converter. Each channel holds two registers of `DATA_W` bits. The first is a staging register that captures the parallel data bus. The second is a code register whose content drives the converter's switch array. Two address bits select which channels a strobe acts on: channel A, channel B, both, or neither.

The write strobe (active low) and the load strobe (active high) are sampled on every rising edge of the system clock and treated as levels. Together they give four cases: capture into the staging register, transfer from the staging register to the code register, pass data straight through both stages, or hold. If the two strobes are tied together and pulsed low, the capture happens while the pulse is low and the transfer happens once it returns high.

A functional clear pin forces all four registers to a preset value. The preset is zero scale or midscale, chosen by a level pin. Each channel's code register is presented to the analog side in two parts. The top four bits become fifteen equally weighted segment lines in thermometer form. The remaining bits pass through as binary ladder bits.

Top module: `dacif_dual_front`

## Requirements
- R1: Address 2'b00 selects channel A, 2'b01 selects no channel, 2'b10 selects both channels, and 2'b11 selects channel B. An unselected channel's registers do not change on a strobe.
- R2: With `clr_n` low at a clock edge, the staging and code registers of both channels take the preset value at that edge, whatever `wr_n`, `ld` and `addr` are.
- R3: The preset is all zeros when `mid_sel` is 0. It is midscale (only bit `DATA_W-1` set) when `mid_sel` is 1.
- R4: With `clr_n`=1, `wr_n`=0 and `ld`=0, the selected staging registers capture `data`, and no code register changes.
- R5: With `clr_n`=1, `wr_n`=1 and `ld`=1, the selected code registers load from their own staging registers.
- R6: With `clr_n`=1, `wr_n`=0 and `ld`=1, the selected staging and code registers both take `data` at the same edge. The outputs show `data` after that edge.
- R7: With `clr_n`=1, `wr_n`=1 and `ld`=0, no register changes.
- R8: When `wr_n` and `ld` are driven together as one pulse, a low level followed by a high level moves `data` into the selected code register. The code register is unchanged after the low cycle alone.
- R9: For a top-four-bit value N, exactly N of the 15 segment lines are high, filled from bit 0 upward (segment i is high when N > i).
- R10: The binary outputs equal code bits `DATA_W-5` down to 0.
- R11: System reset `rst_n` low at a clock edge clears all registers to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| clr_n | input | 1 | Active-low functional clear of all registers |
| mid_sel | input | 1 | Preset select: 0 zero scale, 1 midscale |
| addr | input | 2 | Channel select code |
| data | input | DATA_W | Parallel data bus |
| wr_n | input | 1 | Active-low write strobe level |
| ld | input | 1 | Active-high load strobe level |
| seg_a | output | 15 | Channel A thermometer segment lines |
| lsb_a | output | DATA_W-4 | Channel A binary ladder bits |
| seg_b | output | 15 | Channel B thermometer segment lines |
| lsb_b | output | DATA_W-4 | Channel B binary ladder bits |

## Verification
The assertions check the following on every cycle:
- the segment lines always form a contiguous thermometer;
- the hold case and the no-channel address freeze both outputs;
- a write-only cycle leaves the outputs unchanged;
- a clear produces the preset chosen by `mid_sel`;
- a transparent write to channel A appears on its outputs one edge later.

Some behaviour depends on the hidden staging-register contents. This covers a transfer that delivers data captured many cycles earlier, the split between channel A, channel B and both, and the two-phase tied-strobe pulse. Only the bench's sequences can show these, by comparing against its truth-table model after each change of the control pins.

// File: rtl/dacif_pkg.sv
// Shared definitions for the dual-channel converter code register.
// Assumes the top four code bits always feed a 15-line thermometer.
package dacif_pkg;
    localparam int THERM_BITS = 4;
    localparam int SEG_N      = (1 << THERM_BITS) - 1;
    localparam int CH_N       = 2;

    typedef enum logic [1:0] {
        SEL_CH_A  = 2'b00,
        SEL_NONE  = 2'b01,
        SEL_BOTH  = 2'b10,
        SEL_CH_B  = 2'b11
    } chan_sel_e;
endpackage

// File: rtl/dacif_addr_dec.sv
// Decodes the two-bit channel select into one enable per channel.
// Assumes channel A is bit 0 and channel B is bit 1 of the enable vector.
module dacif_addr_dec
    import dacif_pkg::*;
(
    input  logic [1:0]      addr,
    output logic [CH_N-1:0] ch_en
);
    // Map each select code onto the channels it enables.
    always_comb begin
        unique case (chan_sel_e'(addr))
            SEL_CH_A: ch_en = 2'b01;
            SEL_NONE: ch_en = 2'b00;
            SEL_BOTH: ch_en = 2'b11;
            SEL_CH_B: ch_en = 2'b10;
            default:  ch_en = 2'b00;
        endcase
    end
endmodule

// File: rtl/dacif_chan_regs.sv
// One channel's staging register and code register.
// Strobes are levels evaluated on each clock. The functional clear wins over
// the strobes. The system reset wins over everything.
module dacif_chan_regs #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic [DATA_W-1:0] preset,
    input  logic              en,
    input  logic              cap_stage,
    input  logic              cap_code,
    input  logic              pass_thru,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] code
);
    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] code_q;

    // Update the staging register: reset, clear, or capture the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)                stage_q <= '0;
        else if (!clr_n)           stage_q <= preset;
        else if (en && cap_stage)  stage_q <= data;
    end

    // Update the code register: reset, clear, pass-through, or transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                code_q <= '0;
        else if (!clr_n)           code_q <= preset;
        else if (en && cap_code)   code_q <= pass_thru ? data : stage_q;
    end

    assign code = code_q;
endmodule

// File: rtl/dacif_therm_dec.sv
// Converts the top code bits into equally weighted segment lines.
// A value N raises segments 0..N-1 and leaves the rest low.
module dacif_therm_dec
    import dacif_pkg::*;
(
    input  logic [THERM_BITS-1:0] msb,
    output logic [SEG_N-1:0]      seg
);
    for (genvar i = 0; i < SEG_N; i++) begin : g_seg
        localparam logic [THERM_BITS-1:0] IDX = THERM_BITS'(i);
        // Segment i is high when the value exceeds its index.
        assign seg[i] = (msb > IDX);
    end
endmodule

// File: rtl/dacif_dual_front.sv
// Top: two double-buffered channels with shared strobe decode and outputs
// split into thermometer segments plus binary ladder bits.
// Assumes control pins are already in the clk domain.
module dacif_dual_front
    import dacif_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_n,
    input  logic                     mid_sel,
    input  logic [1:0]               addr,
    input  logic [DATA_W-1:0]        data,
    input  logic                     wr_n,
    input  logic                     ld,
    output logic [SEG_N-1:0]         seg_a,
    output logic [DATA_W-THERM_BITS-1:0] lsb_a,
    output logic [SEG_N-1:0]         seg_b,
    output logic [DATA_W-THERM_BITS-1:0] lsb_b
);
    localparam int LSB_W = DATA_W - THERM_BITS;
    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    logic [CH_N-1:0]   ch_en;
    logic [DATA_W-1:0] preset;
    logic              cap_stage;
    logic              cap_code;
    logic              pass_thru;
    logic [DATA_W-1:0] code   [CH_N];
    logic [SEG_N-1:0]  seg_w  [CH_N];

    dacif_addr_dec u_dec (
        .addr  (addr),
        .ch_en (ch_en)
    );

    // Derive the strobe cases and the clear value from the control pins.
    always_comb begin
        preset    = mid_sel ? MID_CODE : '0;
        cap_stage = !wr_n;
        cap_code  = ld;
        pass_thru = !wr_n && ld;
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        dacif_chan_regs #(.DATA_W(DATA_W)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_n     (clr_n),
            .preset    (preset),
            .en        (ch_en[c]),
            .cap_stage (cap_stage),
            .cap_code  (cap_code),
            .pass_thru (pass_thru),
            .data      (data),
            .code      (code[c])
        );
        dacif_therm_dec u_therm (
            .msb (code[c][DATA_W-1 -: THERM_BITS]),
            .seg (seg_w[c])
        );
    end

    assign seg_a = seg_w[0];
    assign seg_b = seg_w[1];
    assign lsb_a = code[0][LSB_W-1:0];
    assign lsb_b = code[1][LSB_W-1:0];
endmodule

// File: rtl/dacif_dual_front_chk.sv
// Port-level property checker for dacif_dual_front, attached by bind.
module dacif_dual_front_chk #(
    parameter int DATA_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clr_n,
    input logic                 mid_sel,
    input logic [1:0]           addr,
    input logic [DATA_W-1:0]    data,
    input logic                 wr_n,
    input logic                 ld,
    input logic [14:0]          seg_a,
    input logic [DATA_W-5:0]    lsb_a,
    input logic [14:0]          seg_b,
    input logic [DATA_W-5:0]    lsb_b
);
    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] code_a;
    logic [DATA_W-1:0] code_b;
    assign code_a = {4'($countones(seg_a)), lsb_a};
    assign code_b = {4'($countones(seg_b)), lsb_b};

    assert_therm_contig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((({1'b0, seg_a} + 16'd1) & {1'b0, seg_a}) == 16'd0) &&
        ((({1'b0, seg_b} + 16'd1) & {1'b0, seg_b}) == 16'd0));

    assert_hold_case_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clr_n && wr_n && !ld) |=> ($stable(code_a) && $stable(code_b)));

    assert_none_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clr_n && addr == 2'b01) |=> ($stable(code_a) && $stable(code_b)));

    assert_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clr_n && !wr_n && !ld) |=> ($stable(code_a) && $stable(code_b)));

    // Clear value also covers the preset select of R3.
    assert_clear_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !clr_n) |=>
        (code_a == ($past(mid_sel) ? MID_CODE : '0)) &&
        (code_b == ($past(mid_sel) ? MID_CODE : '0)));

    assert_pass_thru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clr_n && !wr_n && ld && addr == 2'b00) |=> (code_a == $past(data)));
endmodule

bind dacif_dual_front dacif_dual_front_chk #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .mid_sel (mid_sel),
    .addr    (addr),
    .data    (data),
    .wr_n    (wr_n),
    .ld      (ld),
    .seg_a   (seg_a),
    .lsb_a   (lsb_a),
    .seg_b   (seg_b),
    .lsb_b   (lsb_b)
);

// File: tb/dacif_dual_front_tb_top.sv
module dacif_dual_front_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int NV = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_n = 1'b1;
    logic mid_sel = 1'b0;
    logic [1:0] addr = 2'b01;
    logic [DW-1:0] data = '0;
    logic wr_n = 1'b1;
    logic ld = 1'b0;
    logic [14:0] seg_a, seg_b;
    logic [DW-5:0] lsb_a, lsb_b;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // model state: staging and code registers per channel
    logic [DW-1:0] m_stage [2];
    logic [DW-1:0] m_code  [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dacif_dual_front #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .mid_sel(mid_sel),
        .addr(addr), .data(data), .wr_n(wr_n), .ld(ld),
        .seg_a(seg_a), .lsb_a(lsb_a), .seg_b(seg_b), .lsb_b(lsb_b)
    );

    // vector: {clr_n, mid_sel, addr[1:0], wr_n, ld, data[15:0]}
    localparam logic [21:0] VEC [NV] = '{
        {1'b1,1'b0,2'b00,1'b0,1'b0,16'h1234},  // write A
        {1'b1,1'b0,2'b00,1'b1,1'b1,16'h0000},  // load A
        {1'b1,1'b0,2'b10,1'b0,1'b0,16'hABCD},  // write both
        {1'b1,1'b0,2'b10,1'b1,1'b0,16'hFFFF},  // hold
        {1'b1,1'b0,2'b11,1'b1,1'b1,16'h0000},  // load B
        {1'b1,1'b0,2'b01,1'b1,1'b1,16'h0000},  // load none
        {1'b1,1'b0,2'b01,1'b0,1'b0,16'h5555},  // write none
        {1'b1,1'b0,2'b10,1'b1,1'b1,16'h0000},  // load both
        {1'b1,1'b0,2'b00,1'b0,1'b1,16'h8001},  // transparent A
        {1'b1,1'b0,2'b10,1'b0,1'b1,16'h0FFF},  // transparent both
        {1'b1,1'b0,2'b11,1'b0,1'b1,16'hF00F},  // transparent B
        {1'b0,1'b1,2'b00,1'b0,1'b1,16'h1111},  // clear midscale
        {1'b1,1'b0,2'b10,1'b1,1'b1,16'h0000},  // load both from preset stage
        {1'b0,1'b0,2'b01,1'b0,1'b0,16'h2222},  // clear zero
        {1'b1,1'b0,2'b11,1'b0,1'b0,16'hF0F0},  // write B
        {1'b1,1'b0,2'b11,1'b1,1'b0,16'h0000},  // hold
        {1'b1,1'b0,2'b11,1'b1,1'b1,16'h0000},  // load B
        {1'b1,1'b0,2'b00,1'b0,1'b1,16'h7FFF},  // transparent A
        {1'b1,1'b0,2'b00,1'b0,1'b1,16'h1000},  // transparent A
        {1'b1,1'b1,2'b10,1'b1,1'b0,16'hEEEE}   // hold with mid_sel high
    };

    function automatic logic [14:0] therm(input int n);
        logic [14:0] t = '0;
        for (int i = 0; i < 15; i++) if (i < n) t[i] = 1'b1;
        return t;
    endfunction

    function automatic string tag_of(input logic [21:0] v);
        if (!v[21])                  return "R2 R3";
        if (v[19:18] == 2'b01)       return "R1";
        if (!v[17] && !v[16])        return "R4";
        if (v[17] && v[16])          return "R5";
        if (!v[17] && v[16])         return "R6";
        return "R7";
    endfunction

    // Truth-table model step for one clock edge.
    task automatic model_step(input logic c, input logic m, input logic [1:0] a,
                              input logic w, input logic l, input logic [DW-1:0] d);
        logic [1:0] en;
        case (a)
            2'b00: en = 2'b01;
            2'b01: en = 2'b00;
            2'b10: en = 2'b11;
            default: en = 2'b10;
        endcase
        for (int ch = 0; ch < 2; ch++) begin
            if (!c) begin
                m_stage[ch] = m ? 16'h8000 : 16'h0000;
                m_code[ch]  = m_stage[ch];
            end else if (en[ch]) begin
                if (l) m_code[ch] = !w ? d : m_stage[ch];
                if (!w) m_stage[ch] = d;
            end
        end
    endtask

    task automatic check_out(input string tag);
        logic [14:0] es [2];
        logic [11:0] el [2];
        for (int ch = 0; ch < 2; ch++) begin
            es[ch] = therm(int'(m_code[ch][15:12]));
            el[ch] = m_code[ch][11:0];
        end
        checks++;
        if (seg_a !== es[0] || lsb_a !== el[0]) begin
            fails++;
            $display("FAIL %s ch A (R9 R10) actual seg=%h lsb=%h expected seg=%h lsb=%h",
                     tag, seg_a, lsb_a, es[0], el[0]);
        end
        checks++;
        if (seg_b !== es[1] || lsb_b !== el[1]) begin
            fails++;
            $display("FAIL %s ch B (R9 R10) actual seg=%h lsb=%h expected seg=%h lsb=%h",
                     tag, seg_b, lsb_b, es[1], el[1]);
        end
    endtask

    task automatic apply(input logic [21:0] v, input string tag);
        clr_n = v[21]; mid_sel = v[20]; addr = v[19:18];
        wr_n = v[17]; ld = v[16]; data = v[15:0];
        model_step(v[21], v[20], v[19:18], v[17], v[16], v[15:0]);
        @(negedge clk);
        check_out(tag);
    endtask

    initial begin
        for (int ch = 0; ch < 2; ch++) begin m_stage[ch] = '0; m_code[ch] = '0; end
        repeat (3) @(negedge clk);
        check_out("R11 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R11 idle after reset");

        for (int k = 0; k < NV; k++) apply(VEC[k], tag_of(VEC[k]));

        // R8: tied strobes, low phase then high phase into channel A
        apply({1'b1,1'b0,2'b00,1'b0,1'b0,16'h4321}, "R8 low phase");
        apply({1'b1,1'b0,2'b00,1'b1,1'b1,16'h0000}, "R8 high phase");
        checks++;
        if ({4'($countones(seg_a)), lsb_a} !== 16'h4321) begin
            fails++;
            $display("FAIL R8 actual=%h expected=4321", {4'($countones(seg_a)), lsb_a});
        end
        // R9: every segment count on channel B via transparent writes
        for (int n = 0; n < 16; n++)
            apply({1'b1,1'b0,2'b11,1'b0,1'b1,4'(n),12'hA5A}, "R9 sweep");
        // R11: system reset mid-run clears to zero even with mid_sel high
        mid_sel = 1'b1; clr_n = 1'b1; wr_n = 1'b1; ld = 1'b0;
        rst_n = 1'b0;
        for (int ch = 0; ch < 2; ch++) begin m_stage[ch] = '0; m_code[ch] = '0; end
        @(negedge clk);
        check_out("R11 mid-run reset");
        rst_n = 1'b1;
        apply({1'b1,1'b0,2'b10,1'b1,1'b1,16'h0000}, "R11 stage cleared");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule